// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Guard

This block is the synchronous front end of a byte-wide parallel flash. It sits between three asynchronous, active-low control pins (chip select, read enable, write enable) and the command state machine. A fast sampling clock brings each pin through a two-flop synchronizer and a hold filter. A level change reaches the control logic only after it has held for `HOLD_CYC` consecutive samples, so short noise pulses never reach it.

A controller state machine turns the filtered pins into one-cycle write strobes. The strobe carries the address and data captured when the write condition began. The controller also applies the logical inhibit, the power-up inhibit and the low-supply lockout. It drives `cmd_rst`, which holds the downstream command machine in its read-array state. The supply comparator is outside this block and delivers a digital flag.

Controller states:
- **ST_RESET**: entered on power-up reset. The filters settle here for `HOLD_CYC+4` cycles. It then moves to ST_LOCKOUT if the supply is low, to ST_INHIBIT if the pins already show the write condition, and to ST_IDLE otherwise.
- **ST_IDLE**: waits for the write condition. When it appears, the controller captures address and data and moves to ST_ARMED.
- **ST_ARMED**: leaves when the write condition ends. It issues a strobe if chip select or write enable rose while read enable was still high. It issues no strobe if read enable fell.
- **ST_INHIBIT**: returns to ST_IDLE once the write condition ends, without issuing a strobe.
- **ST_LOCKOUT**: entered from any state except ST_RESET while the supply flag is set. When the flag clears, it goes to ST_INHIBIT or ST_IDLE, following the same rule as ST_RESET.

Top module: `flash_wr_guard`

## Requirements
- R1: A write is armed only while the filtered pins show the write condition: `ce_n`=0, `we_n`=0 and `oe_n`=1. A completed write produces exactly one `wr_stb`.
- R2: If `oe_n` goes low while a write is armed, the write is abandoned with no strobe. A `we_n` pulse while `ce_n` is high produces no strobe. A cycle with `oe_n` low throughout produces no strobe.
- R3: A low pulse on `ce_n` or `we_n` lasting fewer than `HOLD_CYC` sampling cycles does not start a write.
- R4: `wr_stb` is high for exactly one cycle. `wr_addr` and `wr_data` carry the values present when the write condition was qualified, even if the buses change afterwards.
- R5: While `vcc_low` is set, `cmd_rst` is high and no strobe is issued.
- R6: When `vcc_low` clears, writes are accepted again. A write condition already present at that moment does not produce a strobe; a fresh write cycle is needed.
- R7: If the pins show the write condition when power-up reset releases, the following `we_n` rising edge produces no strobe. The next full write cycle is accepted.
- R8: `cmd_rst` is high during power-up reset and throughout the settle period that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ce_n | input | 1 | Chip select pin, active low, asynchronous |
| oe_n | input | 1 | Read enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| addr_in | input | ADDR_W | Address bus |
| data_in | input | DATA_W | Data bus |
| vcc_low | input | 1 | Supply-below-lockout flag, asynchronous |
| wr_stb | output | 1 | One-cycle write strobe to the command logic |
| wr_addr | output | ADDR_W | Captured write address |
| wr_data | output | DATA_W | Captured write data |
| cmd_rst | output | 1 | Holds the command machine in read-array state |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe lasts one cycle and only ever follows ST_ARMED;
- a set supply flag raises `cmd_rst` on the next cycle;
- no strobe coincides with `cmd_rst`;
- ST_INHIBIT never yields a strobe;
- a filter output changes only after its counter has reached the hold limit.

Other behaviour can only be shown by bench scenarios:
- rejection of short pulses measured in pin time;
- abandonment of a write when `oe_n` falls;
- capture of address and data at arm time;
- the power-up and post-lockout inhibits, where the pins are already low.

// File: rtl/flash_wr_guard_pkg.sv
package flash_wr_guard_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ARMED   = 3'd2,
        ST_INHIBIT = 3'd3,
        ST_LOCKOUT = 3'd4
    } guard_state_e;

endpackage

// File: rtl/fwg_pin_filter.sv
module fwg_pin_filter #(
    parameter int   HOLD_CYC = 3,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_filt
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC - 1);

    logic          meta_q, sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pin_filt <= RST_VAL;
        end else if (sync_q == pin_filt) begin
            cnt_q <= '0;
        end else if (cnt_q == LIMIT) begin
            cnt_q    <= '0;
            pin_filt <= sync_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the filtered level flips only after the full hold window
    p_hold_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_filt != $past(pin_filt)) |-> ($past(cnt_q) == LIMIT));

endmodule

// File: rtl/fwg_ctrl_fsm.sv
module fwg_ctrl_fsm
    import flash_wr_guard_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_f,
    input  logic              oe_f,
    input  logic              we_f,
    input  logic              vcc_low_s,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_rst
);
    localparam int SETTLE_CYC = HOLD_CYC + 4;
    localparam int SW         = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    guard_state_e  state_q, state_d;
    logic [SW-1:0] settle_q;
    logic          settle_done, wr_cond, do_stb, do_latch;

    assign wr_cond     = !ce_f && !we_f && oe_f;
    assign settle_done = (settle_q == SETTLE_LAST);

    always_comb begin
        state_d  = state_q;
        do_stb   = 1'b0;
        do_latch = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                if (settle_done) begin
                    if (vcc_low_s)    state_d = ST_LOCKOUT;
                    else if (wr_cond) state_d = ST_INHIBIT;
                    else              state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (wr_cond) begin
                    state_d  = ST_ARMED;
                    do_latch = 1'b1;
                end
            end
            ST_ARMED: begin
                if (!wr_cond) begin
                    state_d = ST_IDLE;
                    do_stb  = oe_f;
                end
            end
            ST_INHIBIT: begin
                if (!wr_cond) state_d = ST_IDLE;
            end
            ST_LOCKOUT: begin
                if (!vcc_low_s) state_d = wr_cond ? ST_INHIBIT : ST_IDLE;
            end
            default: state_d = ST_RESET;
        endcase
        if (vcc_low_s && state_q != ST_RESET) begin
            state_d  = ST_LOCKOUT;
            do_stb   = 1'b0;
            do_latch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RESET;
            settle_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RESET && !settle_done) settle_q <= settle_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            cmd_rst <= 1'b1;
        end else begin
            wr_stb  <= do_stb;
            cmd_rst <= (state_d == ST_RESET) || (state_d == ST_LOCKOUT);
            if (do_latch) begin
                wr_addr <= addr_in;
                wr_data <= data_in;
            end
        end
    end

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_stb_from_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(state_q) == ST_ARMED));

    p_lockout_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_low_s |=> cmd_rst);

    p_no_stb_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |-> !wr_stb);

    p_inhibit_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INHIBIT) |=> !wr_stb);

endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              vcc_low,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_rst
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pins_raw, pins_f;
    logic            vcc_low_s;

    assign pins_raw = {we_n, oe_n, ce_n};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        fwg_pin_filter #(.HOLD_CYC(HOLD_CYC), .RST_VAL(1'b1)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_async(pins_raw[g]),
            .pin_filt (pins_f[g])
        );
    end

    fwg_pin_filter #(.HOLD_CYC(1), .RST_VAL(1'b0)) u_vcc_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(vcc_low),
        .pin_filt (vcc_low_s)
    );

    fwg_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_f     (pins_f[0]),
        .oe_f     (pins_f[1]),
        .we_f     (pins_f[2]),
        .vcc_low_s(vcc_low_s),
        .addr_in  (addr_in),
        .data_in  (data_in),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd_rst  (cmd_rst)
    );

endmodule

// File: tb/flash_wr_guard_tb_top.sv
module flash_wr_guard_tb_top;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic              vcc_low = 1'b0;
    logic              wr_stb, cmd_rst;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    int n_stb = 0;
    logic [ADDR_W+DATA_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    flash_wr_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYC(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr_in(addr_in), .data_in(data_in), .vcc_low(vcc_low),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .cmd_rst(cmd_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // monitor: compares every strobe against the scoreboard queue (R1, R4)
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            n_stb++;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected strobe actual=%0h expected=none", {wr_addr, wr_data});
            end else begin
                logic [ADDR_W+DATA_W-1:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    n_bad++;
                    $display("FAIL R4 strobe payload actual=%0h expected=%0h", {wr_addr, wr_data}, e);
                end
            end
        end
    end

    // driver: full write cycle; buses change after arm to test capture (R4)
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit expect_stb);
        addr_in = a; data_in = d;
        if (expect_stb) exp_q.push_back({a, d});
        ce_n = 1'b0; we_n = 1'b0;
        wait_clk(8);
        addr_in = ~a; data_in = ~d;
        we_n = 1'b1;
        wait_clk(8);
        ce_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic stb_count(input string req, input int exp);
        wait_clk(4);
        check(req, n_stb, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // power-up with pins already in write state
        wait_clk(5);
        check("R8 cmd_rst in reset", cmd_rst, 1);
        check("R8 wr_stb in reset", wr_stb, 0);
        rst_n = 1'b1;
        wait_clk(2);
        check("R8 cmd_rst during settle", cmd_rst, 1);
        wait_clk(15);
        check("R8 cmd_rst released", cmd_rst, 0);
        we_n = 1'b1;
        wait_clk(10);
        ce_n = 1'b1;
        stb_count("R7 first rise after power-up", 0);
        do_write(17'h0AAAA, 8'h55, 1'b1);
        stb_count("R7 next write accepted", 1);

        // R1: normal writes with different patterns
        do_write(17'h00555, 8'hAA, 1'b1);
        do_write(17'h1FFFF, 8'h00, 1'b1);
        stb_count("R1 two writes", 3);

        // R2: read enable falls during an armed write
        addr_in = 17'h00123; data_in = 8'h12;
        ce_n = 1'b0; we_n = 1'b0;
        wait_clk(8);
        oe_n = 1'b0; wait_clk(8);
        we_n = 1'b1; wait_clk(8);
        oe_n = 1'b1; wait_clk(4);
        ce_n = 1'b1;
        stb_count("R2 oe low abort", 3);
        // R2: we pulse with chip select high
        we_n = 1'b0; wait_clk(8); we_n = 1'b1;
        stb_count("R2 ce high", 3);
        // R2: read cycle with oe low throughout
        oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; wait_clk(8);
        we_n = 1'b1; ce_n = 1'b1; wait_clk(8); oe_n = 1'b1;
        stb_count("R2 oe low throughout", 3);

        // R3: short pulses
        ce_n = 1'b0; wait_clk(8);
        we_n = 1'b0; wait_clk(2); we_n = 1'b1; wait_clk(8);
        ce_n = 1'b1; wait_clk(8);
        we_n = 1'b0; wait_clk(8);
        ce_n = 1'b0; wait_clk(2); ce_n = 1'b1; wait_clk(8);
        we_n = 1'b1;
        stb_count("R3 short pulses", 3);
        do_write(17'h00042, 8'h3C, 1'b1);
        stb_count("R3 long pulse accepted", 4);

        // R5: lockout
        vcc_low = 1'b1;
        wait_clk(6);
        check("R5 cmd_rst in lockout", cmd_rst, 1);
        do_write(17'h00777, 8'h77, 1'b0);
        stb_count("R5 write ignored", 4);
        check("R5 cmd_rst still held", cmd_rst, 1);

        // R6: release with pins in write state, then fresh write
        ce_n = 1'b0; we_n = 1'b0; wait_clk(8);
        vcc_low = 1'b0;
        wait_clk(8);
        check("R6 cmd_rst released", cmd_rst, 0);
        we_n = 1'b1; wait_clk(8); ce_n = 1'b1;
        stb_count("R6 stale write ignored", 4);
        do_write(17'h10F0F, 8'hC3, 1'b1);
        stb_count("R6 fresh write accepted", 5);

        check("R1 scoreboard empty", exp_q.size(), 0);
        finish_run();
    end
endmodule